// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and a 16-bit asynchronous static RAM. The host presents one word access at a time: an 18-bit word address, a write flag, 16 bits of write data and a two-bit byte-enable. The controller sequences the RAM's active-low and active-high chip selects, write strobe, output enable and the two byte-lane selects. It spreads each access over a fixed number of clock cycles. All of those cycle counts come from nanosecond timing parameters and the clock period.

An access runs through four phases after acceptance: setup, access, hold and bus turnaround. During the access phase of a write, the write strobe is low, and the write pulse is the overlap of that strobe with both chip selects and the enabled lanes. During the access phase of a read, the output enable is low. The returned word is registered at the last clock edge of the access phase and flagged by a single-cycle valid pulse. The bidirectional data pins are split into a driven bus, its enable and a sampled input bus. Turnaround cycles keep the controller from driving that bus while the RAM may still be releasing it.

Top module: `asram_ctrl`

## Requirements
- R1: Out of reset and whenever `ready` is high, the RAM pins are parked in standby: `sramCs1N`=1, `sramCs2`=0, `sramWeN`=1, `sramOeN`=1, `sramLbN`=`sramUbN`=1 and `sramDoutEn`=0.
- R2: A request is taken only on a clock edge where `reqValid` and `ready` are both high. `ready` is low from the next cycle. It returns exactly S+A+H+T cycles after the accepting edge, where A is the read or the write access length. A `reqValid` raised while `ready` is low is ignored.
- R3: On a write, `sramWeN` is low for exactly W consecutive cycles, and only while `sramCs1N`=0, `sramCs2`=1, `sramOeN`=1 and `sramDoutEn`=1.
- R4: Byte enables are active high. Bit 0 enables the lower lane (data bits 7:0, select `sramLbN`) and bit 1 enables the upper lane (bits 15:8, select `sramUbN`). A lane select is low during an access only if its enable bit is set, so a write changes only the enabled lanes.
- R5: On a read, `sramOeN` is low for exactly R consecutive cycles with `sramWeN` high. `rdData` is the value of `sramDin` at the last edge of that window.
- R6: `rdValid` is high for exactly one cycle per read, S+R cycles after the accepting edge, and never for a write. In `rdData`, a lane whose enable bit is clear reads as zero.
- R7: With byte enable 0, both lane selects stay high for the whole access. A write then alters no stored byte, and a read returns 0.
- R8: `sramDoutEn` is never high while `sramOeN` is low. After the RAM last drove the bus, at least T cycles pass before `sramDoutEn` rises.
- R9: `sramAddr` equals the accepted address and stays stable while the chip is selected.
- R10: Phase lengths are max(1, ceil(t/period)): S from the address setup time, R from the read cycle time, H from the data hold time and T from the bus release time. W is the larger of the counts from the write pulse width and from the address-valid-to-end-of-write time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Word address |
| reqWdata | input | 16 | Write data |
| reqBe | input | 2 | Byte enables, bit 0 lower lane, bit 1 upper lane |
| ready | output | 1 | Controller can take a request |
| rdData | output | 16 | Read data, disabled lanes zero |
| rdValid | output | 1 | One-cycle read data strobe |
| sramAddr | output | 18 | RAM address pins |
| sramCs1N | output | 1 | Active-low chip select |
| sramCs2 | output | 1 | Active-high chip select |
| sramWeN | output | 1 | Active-low write strobe |
| sramOeN | output | 1 | Active-low output enable |
| sramLbN | output | 1 | Active-low lower lane select |
| sramUbN | output | 1 | Active-low upper lane select |
| sramDout | output | 16 | Data driven toward the RAM |
| sramDoutEn | output | 1 | Enable for the driven data |
| sramDin | input | 16 | Data sampled from the RAM |

## Verification
With the default 5 ns clock the phases are S=1, R=11, W=10, H=1 and T=4. The bench computes these values with its own arithmetic. It counts cycles from the accepting edge and samples only on falling edges. `rdValid` must appear at count S+R. `ready` must return at S+R+H+T after a read and at S+W+H+T after a write.

The RAM model in the bench drives valid data only after the output enable has been low for R cycles. A shortened access window therefore shows up as a wrong word. The model drives a filler pattern on lanes that are not selected, so the lane zeroing is visible. Pulse lengths and turnaround gaps are measured at falling edges, when the pins settle. A sweep covers every byte-enable value at sixteen addresses. Each write is followed by a full-word read and a masked read.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACCESS,
    ST_HOLD,
    ST_TURN
  } phase_e;

  // strobes from control to datapath; selOn..drive describe the next cycle's pins
  typedef struct packed {
    logic load;
    logic capture;
    logic selOn;
    logic weOn;
    logic oeOn;
    logic drive;
  } strobe_t;

  function automatic int nsToCycles(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int RD_CYC    = 11,
  parameter int WR_CYC    = 10,
  parameter int HOLD_CYC  = 1,
  parameter int TURN_CYC  = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    ready,
  output strobe_t stb
);

  localparam int MAXC_A = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int MAXC_B = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int MAXC_C = (MAXC_A > MAXC_B) ? MAXC_A : MAXC_B;
  localparam int MAXC   = (MAXC_C > TURN_CYC) ? MAXC_C : TURN_CYC;
  localparam int CW     = $clog2(MAXC + 1);

  localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] RD_LD    = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WR_LD    = CW'(WR_CYC - 1);
  localparam logic [CW-1:0] HOLD_LD  = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] TURN_LD  = CW'(TURN_CYC - 1);

  phase_e        phase, phaseNext;
  logic [CW-1:0] cnt, cntNext;
  logic          isWr, isWrNext;
  logic          lastCyc;

  assign lastCyc = (cnt == '0);
  assign ready   = (phase == ST_IDLE);

  always_comb begin
    phaseNext   = phase;
    cntNext     = lastCyc ? cnt : cnt - 1'b1;
    isWrNext    = isWr;
    stb.load    = 1'b0;
    stb.capture = 1'b0;
    unique case (phase)
      ST_IDLE: begin
        cntNext = cnt;
        if (reqValid) begin
          stb.load  = 1'b1;
          isWrNext  = reqWrite;
          phaseNext = ST_SETUP;
          cntNext   = SETUP_LD;
        end
      end
      ST_SETUP: if (lastCyc) begin
        phaseNext = ST_ACCESS;
        cntNext   = isWr ? WR_LD : RD_LD;
      end
      ST_ACCESS: if (lastCyc) begin
        stb.capture = !isWr;
        phaseNext   = ST_HOLD;
        cntNext     = HOLD_LD;
      end
      ST_HOLD: if (lastCyc) begin
        phaseNext = ST_TURN;
        cntNext   = TURN_LD;
      end
      ST_TURN: if (lastCyc) begin
        phaseNext = ST_IDLE;
      end
      default: phaseNext = ST_IDLE;
    endcase
    stb.selOn = (phaseNext == ST_SETUP) || (phaseNext == ST_ACCESS) || (phaseNext == ST_HOLD);
    stb.weOn  = (phaseNext == ST_ACCESS) && isWrNext;
    stb.oeOn  = (phaseNext == ST_ACCESS) && !isWrNext;
    stb.drive = stb.selOn && isWrNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= ST_IDLE;
      cnt   <= '0;
      isWr  <= 1'b0;
    end else begin
      phase <= phaseNext;
      cnt   <= cntNext;
      isWr  <= isWrNext;
    end
  end

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath
  import asram_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqBe,
  input  logic [DATA_W-1:0] sramDin,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCs1N,
  output logic              sramCs2,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic              sramLbN,
  output logic              sramUbN,
  output logic [DATA_W-1:0] sramDout,
  output logic              sramDoutEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam int LANE_W = DATA_W / 2;

  logic [1:0]        beQ;
  logic [1:0]        beUse;
  logic [DATA_W-1:0] laneMask;

  assign beUse    = stb.load ? reqBe : beQ;
  assign laneMask = {{LANE_W{beQ[1]}}, {LANE_W{beQ[0]}}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beQ        <= '0;
      sramAddr   <= '0;
      sramDout   <= '0;
      sramCs1N   <= 1'b1;
      sramCs2    <= 1'b0;
      sramWeN    <= 1'b1;
      sramOeN    <= 1'b1;
      sramLbN    <= 1'b1;
      sramUbN    <= 1'b1;
      sramDoutEn <= 1'b0;
      rdData     <= '0;
      rdValid    <= 1'b0;
    end else begin
      if (stb.load) begin
        beQ      <= reqBe;
        sramAddr <= reqAddr;
        sramDout <= reqWdata;
      end
      sramCs1N   <= !stb.selOn;
      sramCs2    <= stb.selOn;
      sramWeN    <= !stb.weOn;
      sramOeN    <= !stb.oeOn;
      sramLbN    <= !(stb.selOn && beUse[0]);
      sramUbN    <= !(stb.selOn && beUse[1]);
      sramDoutEn <= stb.drive;
      rdValid    <= stb.capture;
      if (stb.capture) rdData <= sramDin & laneMask;
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W            = 18,
  parameter int DATA_W            = 16,
  parameter int CLK_PERIOD_NS     = 5,
  parameter int T_ADDR_SETUP_NS   = 0,
  parameter int T_READ_CYCLE_NS   = 55,
  parameter int T_WR_PULSE_NS     = 40,
  parameter int T_ADDR_TO_WEND_NS = 50,
  parameter int T_DATA_HOLD_NS    = 0,
  parameter int T_BUS_RELEASE_NS  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqBe,
  output logic              ready,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCs1N,
  output logic              sramCs2,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic              sramLbN,
  output logic              sramUbN,
  output logic [DATA_W-1:0] sramDout,
  output logic              sramDoutEn,
  input  logic [DATA_W-1:0] sramDin
);

  localparam int SETUP_CYC = nsToCycles(T_ADDR_SETUP_NS, CLK_PERIOD_NS);
  localparam int RD_CYC    = nsToCycles(T_READ_CYCLE_NS, CLK_PERIOD_NS);
  localparam int WP_CYC    = nsToCycles(T_WR_PULSE_NS, CLK_PERIOD_NS);
  localparam int AW_CYC    = nsToCycles(T_ADDR_TO_WEND_NS, CLK_PERIOD_NS);
  localparam int WR_CYC    = (WP_CYC > AW_CYC) ? WP_CYC : AW_CYC;
  localparam int HOLD_CYC  = nsToCycles(T_DATA_HOLD_NS, CLK_PERIOD_NS);
  localparam int TURN_CYC  = nsToCycles(T_BUS_RELEASE_NS, CLK_PERIOD_NS);

  strobe_t stb;

  asram_fsm #(
    .SETUP_CYC(SETUP_CYC),
    .RD_CYC   (RD_CYC),
    .WR_CYC   (WR_CYC),
    .HOLD_CYC (HOLD_CYC),
    .TURN_CYC (TURN_CYC)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .ready   (ready),
    .stb     (stb)
  );

  asram_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .reqBe     (reqBe),
    .sramDin   (sramDin),
    .sramAddr  (sramAddr),
    .sramCs1N  (sramCs1N),
    .sramCs2   (sramCs2),
    .sramWeN   (sramWeN),
    .sramOeN   (sramOeN),
    .sramLbN   (sramLbN),
    .sramUbN   (sramUbN),
    .sramDout  (sramDout),
    .sramDoutEn(sramDoutEn),
    .rdData    (rdData),
    .rdValid   (rdValid)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              ready,
  input logic              rdValid,
  input logic [ADDR_W-1:0] sramAddr,
  input logic              sramCs1N,
  input logic              sramCs2,
  input logic              sramWeN,
  input logic              sramOeN,
  input logic              sramLbN,
  input logic              sramUbN,
  input logic              sramDoutEn
);

  // R1: parked pins whenever the controller is free
  a_r1_idle_standby: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (sramCs1N && !sramCs2 && sramWeN && sramOeN && sramLbN && sramUbN && !sramDoutEn));

  // R2: acceptance drops ready
  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rstN)
    (ready && reqValid) |=> !ready);

  // R3: write strobe only inside a selected, driven, output-disabled window
  a_r3_write_framed: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> (!sramCs1N && sramCs2 && sramOeN && sramDoutEn));

  // R5: never read and write at once
  a_r5_oe_we_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!sramOeN && !sramWeN));

  // R6: valid is a single-cycle pulse
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  // R8: no contention on the data bus
  a_r8_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    !(sramDoutEn && !sramOeN));

  // R9: address held while selected
  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCs1N && $past(!sramCs1N)) |-> $stable(sramAddr));

endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .ready     (ready),
  .rdValid   (rdValid),
  .sramAddr  (sramAddr),
  .sramCs1N  (sramCs1N),
  .sramCs2   (sramCs2),
  .sramWeN   (sramWeN),
  .sramOeN   (sramOeN),
  .sramLbN   (sramLbN),
  .sramUbN   (sramUbN),
  .sramDoutEn(sramDoutEn)
);

// File: tb/asram_ctrl_bench.sv
module asram_ctrl_bench;

  // independent phase arithmetic, 5 ns clock
  function automatic int cyc(input int ns);
    int c;
    c = (ns + 4) / 5;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int S = cyc(0);
  localparam int R = cyc(55);
  localparam int W = (cyc(40) > cyc(50)) ? cyc(40) : cyc(50);
  localparam int H = cyc(0);
  localparam int T = cyc(20);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqBe = '0;
  logic        ready;
  logic [15:0] rdData;
  logic        rdValid;
  logic [17:0] sramAddr;
  logic        sramCs1N, sramCs2, sramWeN, sramOeN, sramLbN, sramUbN;
  logic [15:0] sramDout;
  logic        sramDoutEn;
  logic [15:0] sramDin;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  asram_ctrl u_asram_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe), .ready(ready),
    .rdData(rdData), .rdValid(rdValid), .sramAddr(sramAddr),
    .sramCs1N(sramCs1N), .sramCs2(sramCs2), .sramWeN(sramWeN),
    .sramOeN(sramOeN), .sramLbN(sramLbN), .sramUbN(sramUbN),
    .sramDout(sramDout), .sramDoutEn(sramDoutEn), .sramDin(sramDin)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // RAM model: 64 words indexed by low address bits
  logic [15:0] mem [64];
  int  oeAge = 0;
  int  weLen = 0;
  int  quiet = 100;
  logic prevEn = 1'b0;
  wire chipOn  = !sramCs1N && sramCs2;
  wire rdOn    = chipOn && sramWeN && !sramOeN;
  wire wrOn    = chipOn && !sramWeN && (!sramLbN || !sramUbN);
  wire [15:0] word = mem[sramAddr[5:0]];

  always_comb begin
    if (rdOn && oeAge >= R)
      sramDin = {sramUbN ? 8'hEE : word[15:8], sramLbN ? 8'hEE : word[7:0]};
    else if (rdOn)
      sramDin = 16'h5A5A;
    else
      sramDin = 16'hC3C3;
  end

  initial for (int i = 0; i < 64; i++) mem[i] = '0;

  always @(negedge clk) if (rstN) begin
    oeAge <= rdOn ? oeAge + 1 : 0;
    if (wrOn) begin
      if (!sramLbN) mem[sramAddr[5:0]][7:0]  <= sramDout[7:0];
      if (!sramUbN) mem[sramAddr[5:0]][15:8] <= sramDout[15:8];
    end
    if (!sramWeN) weLen <= weLen + 1;
    else if (weLen > 0) begin
      check(weLen == W, "R3 write pulse length", weLen, W);
      weLen <= 0;
    end
    check(!(sramDoutEn && rdOn), "R8 bus contention", 1, 0);
    if (rdOn) quiet <= 0;
    else if (!sramDoutEn) quiet <= quiet + 1;
    if (sramDoutEn && !prevEn)
      check(quiet >= T, "R8 turnaround gap", quiet, T);
    prevEn <= sramDoutEn;
  end

  task automatic doOp(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] be,
                      output logic [15:0] rd, output int vLat, output int rLat, output int vCnt);
    int n;
    @(negedge clk);
    while (!ready) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqBe = be;
    @(posedge clk);
    n = -1; vLat = -1; rLat = -1; vCnt = 0; rd = '0;
    forever begin
      @(negedge clk);
      n++;
      if (n == 0) reqValid = 1'b0;
      if (n == 2) begin
        reqValid = 1'b1; reqWrite = 1'b1; reqAddr = ~a; reqWdata = 16'hBAD0; reqBe = 2'b11;
      end
      if (n == 3) reqValid = 1'b0;
      if (!sramCs1N) check(sramAddr == a, "R9 address", sramAddr, a);
      if (rdValid) begin vCnt++; vLat = n; rd = rdData; end
      if (ready || n > 200) begin rLat = n; break; end
    end
  endtask

  logic [15:0] shadow [64];

  initial begin
    logic [15:0] rd;
    int vLat, rLat, vCnt;
    for (int i = 0; i < 64; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(ready === 1'b1, "R1 ready in reset", ready, 1);
    check({sramCs1N, sramCs2, sramWeN, sramOeN, sramLbN, sramUbN, sramDoutEn} == 7'b1011110,
          "R1 standby pins", {sramCs1N, sramCs2, sramWeN, sramOeN, sramLbN, sramUbN, sramDoutEn}, 7'b1011110);
    check(rdValid == 1'b0, "R1 no valid", rdValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(ready == 1'b1 && sramCs1N && !sramDoutEn, "R1 idle after reset", ready, 1);

    for (int i = 0; i < 16; i++) begin
      logic [17:0] a;
      a = {12'(i * 293 + 7), 6'(i * 3)};
      for (int be = 0; be < 4; be++) begin
        logic [15:0] d, m;
        d = 16'(i * 16'h1357 + be * 16'h2468 + 16'h0F0F);
        m = {{8{be[1]}}, {8{be[0]}}};
        doOp(1'b1, a, d, 2'(be), rd, vLat, rLat, vCnt);
        shadow[a[5:0]] = (shadow[a[5:0]] & ~m) | (d & m);
        check(rLat == S + W + H + T, "R2 write ready latency (R10)", rLat, S + W + H + T);
        check(vCnt == 0, "R6 no valid on write", vCnt, 0);
        // full read: R4 lane update, R7 be=0 leaves word alone
        doOp(1'b0, a, 16'h0, 2'b11, rd, vLat, rLat, vCnt);
        check(rd == shadow[a[5:0]], "R4 R7 stored word", rd, shadow[a[5:0]]);
        check(vCnt == 1 && vLat == S + R, "R6 valid timing (R5)", vLat, S + R);
        check(rLat == S + R + H + T, "R2 read ready latency (R10)", rLat, S + R + H + T);
        // masked read: disabled lanes zero
        doOp(1'b0, a, 16'h0, 2'(be), rd, vLat, rLat, vCnt);
        check(rd == (shadow[a[5:0]] & m), "R6 masked read", rd, shadow[a[5:0]] & m);
      end
    end
    // R2: junk requests while busy never landed at the complemented address
    for (int i = 0; i < 16; i++) begin
      logic [17:0] a;
      a = {12'(i * 293 + 7), 6'(i * 3)};
      doOp(1'b0, ~a, 16'h0, 2'b11, rd, vLat, rLat, vCnt);
      check(rd == shadow[(~a) & 18'h3F], "R2 ignored busy request", rd, shadow[(~a) & 18'h3F]);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule